// File: doc/BRIEF.md
# Asynchronous Memory Bank-Enable Controller

This block is the control side of an external asynchronous memory port with four banks. It keeps one 16-bit global control word and two 32-bit bank control words. Software reaches them through a small register bus that carries a strobe, a write enable, an offset, an access-size code and write data. Every strobe receives a registered response one cycle later, with read data and an error flag, so the bus never waits.

A three-bit field of the global word gives the number of enabled banks, counted upward from bank 0. Values above four count as four. The memory side is decoded combinationally. A memory address inside the four-bank window selects one bank's chip select, but only if that bank is enabled. Addresses outside the window, or in a disabled bank, select nothing. The bank size is a power of two set at build time, typically 1 MiB or 64 MiB.

The block also rejects register accesses of the wrong size and accesses to offsets that are not defined. A rejected access raises the error flag and leaves all state as it was.

Top module: `amc_bank_ctrl`

## Requirements
- R1: After reset the global word reads 0x00F2 and both bank control words read 0xFFC2FFC2. The enable field is therefore 1, and only bank 0 is enabled.
- R2: The enabled bank count is bits [3:1] of the global word. Any field value of 5, 6 or 7 gives a count of 4.
- R3: Bank i covers [WIN_BASE + i*2^BANK_LOG2, WIN_BASE + (i+1)*2^BANK_LOG2) for i in 0..3. A selected bank i drives mem_cs bit i, with at most one bit set, and raises mem_hit. An address outside the whole window drives mem_cs = 0 and mem_hit = 0.
- R4: An address inside bank i selects it only when i is less than the enabled count. Otherwise mem_cs = 0 and mem_hit = 0.
- R5: The global word is at offset 0 and takes only size code 1 (16 bits). A write stores wdata[15:0]. A read returns the word in bits [15:0] with bits [31:16] zero.
- R6: The bank control words are at offsets 4 (first) and 8 (second) and take only size code 2 (32 bits). They read back exactly what was written.
- R7: An access to a defined offset with the wrong size code (code 0 = byte, code 3 = reserved, or code 1/2 on the wrong register) raises rsp_err, returns read data 0 and changes no register.
- R8: An access to any offset other than 0, 4 and 8 raises rsp_err, returns read data 0 and changes no register.
- R9: Each strobe cycle is followed by exactly one cycle with rsp_valid high, and rsp_err is high only in such a cycle. A cycle without a strobe is followed by rsp_valid = 0 and rsp_err = 0.
- R10: A global write changes the bank decode from the cycle after the strobe. In the strobe cycle itself, the decode still uses the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_sel | input | 1 | Register access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_off | input | OFF_W | Register byte offset |
| acc_size | input | 2 | Size code: 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle, one cycle after the strobe |
| rsp_rdata | output | 32 | Read data (0 on writes and rejected accesses) |
| rsp_err | output | 1 | Rejected-access pulse, coincides with rsp_valid |
| mem_addr | input | ADDR_W | Memory address to decode |
| mem_cs | output | 4 | Chip select, one bit per bank |
| mem_hit | output | 1 | Address falls in an enabled bank |

## Verification
A register write that changes the enable field can land in the same cycle as a memory address aimed at a bank whose enable depends on that write. The bench holds an address in bank 2 while it strobes a write that raises the count from 1 to 3. It samples the chip selects before the clock edge, where they must still be zero, and again after the edge, where bank 2 must be selected. Around this, the decode is swept over every address of a small window for all eight field values, and every offset and size pairing is driven through the register bus. Each result is compared with values the bench works out arithmetically.

// File: rtl/amc_pkg.sv
package amc_pkg;
  localparam int NUM_BANKS = 4;
  localparam int NUM_BCTL  = 2;
  localparam int GLB_W     = 16;
  localparam int EN_LSB    = 1;
  localparam int EN_W      = 3;
  localparam int CNT_W     = $clog2(NUM_BANKS + 1);
  localparam int OFF_GLB   = 0;
  localparam int OFF_BCTL0 = 4;
  localparam int OFF_STEP  = 4;

  localparam logic [GLB_W-1:0] GLB_RST  = 16'h00F2;
  localparam logic [31:0]      BCTL_RST = 32'hFFC2_FFC2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/amc_regfile.sv
module amc_regfile
  import amc_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_sel,
  input  logic             acc_we,
  input  logic [OFF_W-1:0] acc_off,
  input  logic [1:0]       acc_size,
  input  logic [31:0]      acc_wdata,
  output logic [EN_W-1:0]  en_field,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_err
);
  logic [GLB_W-1:0]    glb_q;
  logic [31:0]         bctl_q [NUM_BCTL];
  logic                glb_hit;
  logic [NUM_BCTL-1:0] bctl_hit;
  logic                off_ok, size_ok, acc_ok;
  logic [31:0]         rd_next;

  assign glb_hit = (acc_off == OFF_W'(OFF_GLB));

  for (genvar k = 0; k < NUM_BCTL; k++) begin : g_hit
    assign bctl_hit[k] = (acc_off == OFF_W'(OFF_BCTL0 + k * OFF_STEP));
  end

  always_comb begin
    off_ok  = glb_hit | (|bctl_hit);
    size_ok = glb_hit ? (acc_size == SZ_HALF) : (acc_size == SZ_WORD);
    acc_ok  = off_ok & size_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_q <= GLB_RST;
    end else if (acc_sel && acc_we && acc_ok && glb_hit) begin
      glb_q <= acc_wdata[GLB_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_BCTL; k++) begin
      if (rst) begin
        bctl_q[k] <= BCTL_RST;
      end else if (acc_sel && acc_we && acc_ok && bctl_hit[k]) begin
        bctl_q[k] <= acc_wdata;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (acc_ok) begin
      if (glb_hit) rd_next = {{(32-GLB_W){1'b0}}, glb_q};
      for (int k = 0; k < NUM_BCTL; k++) begin
        if (bctl_hit[k]) rd_next = bctl_q[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_sel;
      rsp_err   <= acc_sel & ~acc_ok;
      rsp_rdata <= (acc_sel && !acc_we) ? rd_next : '0;
    end
  end

  assign en_field = glb_q[EN_LSB +: EN_W];

  p_resp_after_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    acc_sel |=> rsp_valid);
  p_no_resp_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !acc_sel |=> (!rsp_valid && !rsp_err));
  p_err_in_resp_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid);
  p_glb_hold_bad_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_sel && acc_we && !acc_ok) |=> $stable(glb_q));

  for (genvar k = 0; k < NUM_BCTL; k++) begin : g_chk
    p_bctl_hold_bad_r8: assert property (@(posedge clk) disable iff (rst)
      (acc_sel && acc_we && !acc_ok) |=> $stable(bctl_q[k]));
  end
endmodule

// File: rtl/amc_bank_decode.sv
module amc_bank_decode
  import amc_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE  = '0,
  parameter int                BANK_LOG2 = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CNT_W-1:0]     bank_cnt,
  output logic [NUM_BANKS-1:0] cs,
  output logic                 hit
);
  logic [ADDR_W-1:0] rel_addr;
  logic [ADDR_W-1:0] bank_no;
  logic              in_win;

  always_comb begin
    rel_addr = addr - WIN_BASE;
    bank_no  = rel_addr >> BANK_LOG2;
    in_win   = (bank_no < ADDR_W'(NUM_BANKS));
    hit      = in_win && (bank_no < ADDR_W'(bank_cnt));
  end

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_cs
    assign cs[k] = in_win && (bank_no == ADDR_W'(k)) && (CNT_W'(k) < bank_cnt);

    p_cs_enabled_r4: assert property (@(posedge clk) disable iff (rst)
      cs[k] |-> (bank_cnt > CNT_W'(k)));
  end

  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs));
  p_hit_agrees_r4: assert property (@(posedge clk) disable iff (rst)
    hit == (cs != '0));
endmodule

// File: rtl/amc_bank_ctrl.sv
module amc_bank_ctrl
  import amc_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h2000_0000,
  parameter int                BANK_LOG2 = 20,
  parameter int                OFF_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_sel,
  input  logic                 acc_we,
  input  logic [OFF_W-1:0]     acc_off,
  input  logic [1:0]           acc_size,
  input  logic [31:0]          acc_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic                 rsp_err,
  input  logic [ADDR_W-1:0]    mem_addr,
  output logic [NUM_BANKS-1:0] mem_cs,
  output logic                 mem_hit
);
  logic [EN_W-1:0]  en_field;
  logic [CNT_W-1:0] bank_cnt;

  amc_regfile #(.OFF_W(OFF_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .acc_sel   (acc_sel),
    .acc_we    (acc_we),
    .acc_off   (acc_off),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .en_field  (en_field),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  // clamp of the enable field to the number of banks (R2)
  always_comb begin
    if (CNT_W'(en_field) > CNT_W'(NUM_BANKS)) bank_cnt = CNT_W'(NUM_BANKS);
    else                                      bank_cnt = CNT_W'(en_field);
  end

  amc_bank_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_BASE  (WIN_BASE),
    .BANK_LOG2 (BANK_LOG2)
  ) u_dec (
    .clk      (clk),
    .rst      (rst),
    .addr     (mem_addr),
    .bank_cnt (bank_cnt),
    .cs       (mem_cs),
    .hit      (mem_hit)
  );

  p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (rst)
    (en_field >= EN_W'(NUM_BANKS)) |-> (bank_cnt == CNT_W'(NUM_BANKS)));
endmodule

// File: tb/amc_bank_ctrl_test.sv
`timescale 1ns/100ps
module amc_bank_ctrl_test;
  localparam int          AW    = 12;
  localparam logic [11:0] BASE  = 12'h400;
  localparam int          BLOG2 = 4;
  localparam int          BSIZE = 1 << BLOG2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_sel = 1'b0, acc_we = 1'b0;
  logic [3:0]  acc_off = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [AW-1:0] mem_addr = '0;
  logic [3:0]  mem_cs;
  logic        mem_hit;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  amc_bank_ctrl #(.ADDR_W(AW), .WIN_BASE(BASE), .BANK_LOG2(BLOG2), .OFF_W(4)) uut (
    .clk(clk), .rst(rst), .acc_sel(acc_sel), .acc_we(acc_we), .acc_off(acc_off),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .mem_addr(mem_addr),
    .mem_cs(mem_cs), .mem_hit(mem_hit)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit we, input int off, input int sz, input logic [31:0] wd,
                     output logic [31:0] rd, output logic er, output logic vl);
    @(negedge clk);
    acc_sel = 1'b1; acc_we = we; acc_off = off[3:0]; acc_size = sz[1:0]; acc_wdata = wd;
    @(negedge clk);
    vl = rsp_valid; er = rsp_err; rd = rsp_rdata;
    acc_sel = 1'b0; acc_we = 1'b0;
  endtask

  function automatic bit legal(input int off, input int sz);
    return (off == 0 && sz == 1) || ((off == 4 || off == 8) && sz == 2);
  endfunction

  function automatic logic [3:0] exp_cs(input int a, input int field);
    int cnt;
    int b;
    cnt = (field > 4) ? 4 : field;
    if (a >= int'(BASE) && a < int'(BASE) + 4 * BSIZE) begin
      b = (a - int'(BASE)) / BSIZE;
      if (b < cnt) return 4'(1 << b);
    end
    return 4'b0;
  endfunction

  logic [15:0] glb_m;
  logic [31:0] bctl_m [2];

  task automatic check_regs(input string tag);
    logic [31:0] rd; logic er, vl;
    acc(1'b0, 0, 1, '0, rd, er, vl);
    check(rd == {16'h0, glb_m} && !er && vl, {tag, " R5 global readback"}, rd, {16'h0, glb_m});
    acc(1'b0, 4, 2, '0, rd, er, vl);
    check(rd == bctl_m[0] && !er && vl, {tag, " R6 bank ctl 0 readback"}, rd, bctl_m[0]);
    acc(1'b0, 8, 2, '0, rd, er, vl);
    check(rd == bctl_m[1] && !er && vl, {tag, " R6 bank ctl 1 readback"}, rd, bctl_m[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic er, vl;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 / R1: idle response and reset contents
    check(!rsp_valid && !rsp_err, "R9 idle after reset", {30'd0, rsp_valid, rsp_err}, 32'd0);
    glb_m = 16'h00F2; bctl_m[0] = 32'hFFC2_FFC2; bctl_m[1] = 32'hFFC2_FFC2;
    check_regs("R1 reset");
    mem_addr = BASE; #1;
    check(mem_cs == 4'b0001 && mem_hit, "R1 reset bank0 enabled", {27'd0, mem_hit, mem_cs}, 32'h11);
    mem_addr = BASE + 12'(BSIZE); #1;
    check(mem_cs == 4'b0000 && !mem_hit, "R1 reset bank1 disabled", {27'd0, mem_hit, mem_cs}, 32'h0);

    // R2 / R3 / R4: full address sweep for every enable field value
    for (int f = 0; f < 8; f++) begin
      acc(1'b1, 0, 1, {16'hBEEF, 12'h0F0, 3'(f), 1'b0}, rd, er, vl);
      check(!er && vl, "R5 global write accepted", {30'd0, vl, er}, 32'h2);
      @(negedge clk);
      for (int a = 0; a < (1 << AW); a++) begin
        logic [3:0] e;
        mem_addr = AW'(a); #0.1;
        e = exp_cs(a, f);
        check(mem_cs == e && mem_hit == (e != 0), "R2 R3 R4 decode sweep",
              {19'd0, AW'(a), 1'b0}, {27'd0, (e != 0), e});
        if (mem_cs != e) $display("  detail field=%0d addr=0x%03h cs=%b", f, a, mem_cs);
      end
    end

    // R10: global write and decode in the same cycle
    acc(1'b1, 0, 1, 32'h0000_00F2, rd, er, vl);
    mem_addr = BASE + 12'(2 * BSIZE + 3);
    @(negedge clk);
    acc_sel = 1'b1; acc_we = 1'b1; acc_off = 4'd0; acc_size = 2'd1; acc_wdata = 32'h0000_00F6;
    #1;
    check(mem_cs == 4'b0000 && !mem_hit, "R10 old count in strobe cycle", {27'd0, mem_hit, mem_cs}, 32'h0);
    @(negedge clk);
    acc_sel = 1'b0; acc_we = 1'b0;
    check(mem_cs == 4'b0100 && mem_hit, "R10 new count next cycle", {27'd0, mem_hit, mem_cs}, 32'h14);
    check(rsp_valid && !rsp_err, "R9 response for write", {30'd0, rsp_valid, rsp_err}, 32'h2);
    @(negedge clk);
    check(!rsp_valid && !rsp_err, "R9 single response cycle", {30'd0, rsp_valid, rsp_err}, 32'h0);
    glb_m = 16'h00F6;

    // R5..R8: every offset and size code, write then read
    for (int off = 0; off < 16; off++) begin
      for (int sz = 0; sz < 4; sz++) begin
        logic [31:0] wd;
        bit ok;
        ok = legal(off, sz);
        wd = 32'hA500_0000 ^ (off << 12) ^ (sz << 4) ^ 32'h0000_0C03;
        acc(1'b1, off, sz, wd, rd, er, vl);
        check(vl && er == !ok, ok ? "R5 R6 legal write" : ((off == 0 || off == 4 || off == 8) ? "R7 wrong size write" : "R8 bad offset write"),
              {30'd0, vl, er}, {30'd0, 1'b1, !ok});
        if (ok) begin
          if (off == 0) glb_m = wd[15:0];
          else if (off == 4) bctl_m[0] = wd;
          else bctl_m[1] = wd;
        end
        acc(1'b0, off, sz, '0, rd, er, vl);
        if (ok) begin
          logic [31:0] ex;
          ex = (off == 0) ? {16'h0, glb_m} : (off == 4) ? bctl_m[0] : bctl_m[1];
          check(rd == ex && !er, "R5 R6 legal read", rd, ex);
        end else begin
          check(rd == 32'h0 && er, (off == 0 || off == 4 || off == 8) ? "R7 wrong size read" : "R8 bad offset read", rd, 32'h0);
        end
        @(negedge clk);
        check(!rsp_valid && !rsp_err, "R9 error pulse ends", {30'd0, rsp_valid, rsp_err}, 32'h0);
        check_regs(ok ? "legal" : "R7 R8 state unchanged");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule